// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block does the interrupt bookkeeping for a serial controller with two channels, A and B. Each channel raises receive and transmit requests and gets clear pulses from the surrounding logic. For each channel the block tracks whether a receive or transmit interrupt is pending and whether it is in service. It keeps a shared interrupt-pending status byte and a modified interrupt vector. The vector encodes which source last changed state. Its bit layout depends on a status-high/low select.

A receive interrupt in service holds off the transmit interrupt of the same channel. A clear-in-service command, or a clear of the other source, hands a request that is still pending straight back into service. All channels' interrupt conditions are ORed onto one request line. Software reads the status byte and the vector through register logic outside this block.

Top module: `sirq_ctrl`

## Requirements
- R1: A receive request on a channel sets its receive-pending and receive-in-service flags and its receive status bit. It loads the vector with that channel's receive code.
- R2: A transmit request always sets transmit-pending. The request enters service and loads the vector with the transmit code only when, after that cycle's other actions, no receive is in service on that channel. Otherwise the vector and the transmit status bit are left as they were.
- R3: With the status-low layout (stat_hi = 0) the vector codes are: A receive 0x0C, A transmit 0x08, B receive 0x04, B transmit 0x00, no interrupt 0x06.
- R4: With the status-high layout (stat_hi = 1) the vector codes are: A receive 0x30, A transmit 0x10, B receive 0x20, B transmit 0x00, no interrupt 0x60.
- R5: pend_stat has A receive at bit 5, A transmit at bit 4, B receive at bit 2 and B transmit at bit 1. Its other bits are 0. A transmit bit is set, as transmit enters service, only when that channel's tx_ie bit is 1.
- R6: A clear-in-service command clears receive-in-service if it is set. If transmit is then pending, transmit enters service and the vector takes the transmit code. If receive was not in service, the command clears transmit-in-service. The pending flags are not changed.
- R7: A receive clear drops receive-pending, receive-in-service and the receive status bit, and loads the no-interrupt code. If transmit is still pending it then re-enters service as in R2.
- R8: A transmit clear drops transmit-pending, transmit-in-service and the transmit status bit, and loads the no-interrupt code. If receive is still pending it then re-enters service as in R1.
- R9: A channel asks for an interrupt when any of these holds: transmit is pending and tx_ie is 1; receive is pending and its 2-bit receive mode is 01 or 10; brk_ie and brk_stat are both 1. irq is the OR of both channels and follows the configuration inputs with no delay.
- R10: Flags, status bits and the vector change on the clock edge that samples a pulse. Within one channel and cycle the actions apply in this order: clear-in-service, receive clear, transmit clear, receive request, transmit request. A request therefore wins over a clear of the same source. When both channels update the vector in the same cycle, channel A's code is kept.
- R11: Synchronous reset clears every flag and status bit and sets the vector to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_req | input | 2 | Receive request pulse, bit 0 = A, bit 1 = B |
| tx_req | input | 2 | Transmit request pulse per channel |
| rx_clr | input | 2 | Receive clear pulse per channel |
| tx_clr | input | 2 | Transmit clear pulse per channel |
| svc_clr | input | 2 | Clear-in-service command pulse per channel |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, A in [1:0], B in [3:2] |
| brk_ie | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break status per channel |
| stat_hi | input | 1 | Vector layout select, 1 = status high |
| irq | output | 1 | Combined interrupt request |
| pend_stat | output | 8 | Interrupt-pending status byte |
| vec | output | 8 | Modified interrupt vector |

## Verification
The assertions check on every cycle that a request leaves its pending flags set on the next cycle and that nothing is in service without being pending. They also check that a transmit status bit never rises while its enable is off and that the vector never moves without a request or clear pulse in the cycle before. The exact vector codes in both layouts, the handover of a waiting transmit on clear-in-service and on a receive clear, and the same-cycle priorities can only be shown by the bench scenarios. The same holds for the qualification of irq by receive mode, transmit enable and break.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int NCH   = 2;
    localparam int VEC_W = 8;

    typedef enum logic [1:0] {
        EV_HOLD = 2'd0,
        EV_IDLE = 2'd1,
        EV_RX   = 2'd2,
        EV_TX   = 2'd3
    } vec_ev_e;

    typedef struct packed {
        logic rx_pend;
        logic tx_pend;
        logic rx_svc;
        logic tx_svc;
        logic rx_stat;
        logic tx_stat;
    } chan_state_t;

    function automatic logic [VEC_W-1:0] vec_code(input logic hi,
                                                  input logic is_b,
                                                  input vec_ev_e ev);
        logic [VEC_W-1:0] c;
        c = '0;
        if (hi) begin
            case (ev)
                EV_RX:   c = is_b ? 8'h20 : 8'h30;
                EV_TX:   c = is_b ? 8'h00 : 8'h10;
                default: c = 8'h60;
            endcase
        end else begin
            case (ev)
                EV_RX:   c = is_b ? 8'h04 : 8'h0C;
                EV_TX:   c = is_b ? 8'h00 : 8'h08;
                default: c = 8'h06;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sirq_chan.sv
module sirq_chan
    import sirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_req,
    input  logic       tx_req,
    input  logic       rx_clr,
    input  logic       tx_clr,
    input  logic       svc_clr,
    input  logic       tx_ie,
    input  logic [1:0] rx_mode,
    input  logic       brk_ie,
    input  logic       brk_stat,
    output vec_ev_e    ev,
    output logic       rx_stat,
    output logic       tx_stat,
    output logic       req
);

    chan_state_t q, n;

    always_comb begin
        n  = q;
        ev = EV_HOLD;
        // clear-in-service command
        if (svc_clr) begin
            if (n.rx_svc) begin
                n.rx_svc = 1'b0;
                if (n.tx_pend) begin
                    n.tx_svc  = 1'b1;
                    n.tx_stat = n.tx_stat | tx_ie;
                    ev        = EV_TX;
                end
            end else begin
                n.tx_svc = 1'b0;
            end
        end
        // receive clear, waiting transmit re-enters service
        if (rx_clr) begin
            n.rx_pend = 1'b0;
            n.rx_svc  = 1'b0;
            n.rx_stat = 1'b0;
            ev        = EV_IDLE;
            if (n.tx_pend) begin
                n.tx_svc  = 1'b1;
                n.tx_stat = n.tx_stat | tx_ie;
                ev        = EV_TX;
            end
        end
        // transmit clear, waiting receive re-enters service
        if (tx_clr) begin
            n.tx_pend = 1'b0;
            n.tx_svc  = 1'b0;
            n.tx_stat = 1'b0;
            ev        = EV_IDLE;
            if (n.rx_pend) begin
                n.rx_svc  = 1'b1;
                n.rx_stat = 1'b1;
                ev        = EV_RX;
            end
        end
        // requests last so they win over clears
        if (rx_req) begin
            n.rx_pend = 1'b1;
            n.rx_svc  = 1'b1;
            n.rx_stat = 1'b1;
            ev        = EV_RX;
        end
        if (tx_req) begin
            n.tx_pend = 1'b1;
            if (!n.rx_svc) begin
                n.tx_svc  = 1'b1;
                n.tx_stat = n.tx_stat | tx_ie;
                ev        = EV_TX;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign rx_stat = q.rx_stat;
    assign tx_stat = q.tx_stat;
    assign req     = (tx_ie & q.tx_pend)
                   | (((rx_mode == 2'b01) || (rx_mode == 2'b10)) & q.rx_pend)
                   | (brk_ie & brk_stat);

    // R1
    rx_req_sets_chk: assert property (@(posedge clk) disable iff (rst)
        rx_req |=> (q.rx_pend && q.rx_svc && q.rx_stat));

    // R2
    tx_req_pends_chk: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> q.tx_pend);

    // R6
    svc_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (q.rx_svc |-> q.rx_pend) and (q.tx_svc |-> q.tx_pend));

    // R8
    tx_clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_clr && !tx_req) |=> (!q.tx_pend && !q.tx_stat));

endmodule

// File: rtl/sirq_vec.sv
module sirq_vec
    import sirq_pkg::*;
#(
    parameter logic [VEC_W-1:0] RST_VEC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stat_hi,
    input  vec_ev_e          ev_a,
    input  vec_ev_e          ev_b,
    output logic [VEC_W-1:0] vec
);

    always_ff @(posedge clk) begin
        if (rst)                 vec <= RST_VEC;
        else if (ev_a != EV_HOLD) vec <= vec_code(stat_hi, 1'b0, ev_a);
        else if (ev_b != EV_HOLD) vec <= vec_code(stat_hi, 1'b1, ev_b);
    end

endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
#(
    parameter logic [VEC_W-1:0] RST_VEC = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH-1:0]      rx_req,
    input  logic [NCH-1:0]      tx_req,
    input  logic [NCH-1:0]      rx_clr,
    input  logic [NCH-1:0]      tx_clr,
    input  logic [NCH-1:0]      svc_clr,
    input  logic [NCH-1:0]      tx_ie,
    input  logic [2*NCH-1:0]    rx_mode,
    input  logic [NCH-1:0]      brk_ie,
    input  logic [NCH-1:0]      brk_stat,
    input  logic                stat_hi,
    output logic                irq,
    output logic [VEC_W-1:0]    pend_stat,
    output logic [VEC_W-1:0]    vec
);

    vec_ev_e        ev_w [NCH];
    logic [NCH-1:0] st_rx, st_tx, req_w;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        sirq_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .rx_req   (rx_req[g]),
            .tx_req   (tx_req[g]),
            .rx_clr   (rx_clr[g]),
            .tx_clr   (tx_clr[g]),
            .svc_clr  (svc_clr[g]),
            .tx_ie    (tx_ie[g]),
            .rx_mode  (rx_mode[2*g +: 2]),
            .brk_ie   (brk_ie[g]),
            .brk_stat (brk_stat[g]),
            .ev       (ev_w[g]),
            .rx_stat  (st_rx[g]),
            .tx_stat  (st_tx[g]),
            .req      (req_w[g])
        );
    end

    sirq_vec #(.RST_VEC(RST_VEC)) u_vec (
        .clk     (clk),
        .rst     (rst),
        .stat_hi (stat_hi),
        .ev_a    (ev_w[0]),
        .ev_b    (ev_w[1]),
        .vec     (vec)
    );

    // channel A in the upper nibble, channel B in the lower one
    assign pend_stat = {2'b00, st_rx[0], st_tx[0], 1'b0, st_rx[1], st_tx[1], 1'b0};
    assign irq       = |req_w;

    // R5
    tx_bit_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(pend_stat[4]) |-> $past(tx_ie[0])) and
        ($rose(pend_stat[1]) |-> $past(tx_ie[1])));

    // R10
    vec_moves_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(vec) |-> $past(|(rx_req | tx_req | rx_clr | tx_clr | svc_clr)));

endmodule

// File: tb/test_sirq_ctrl.sv
`timescale 1ns/1ps
module test_sirq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rx_req = '0, tx_req = '0, rx_clr = '0, tx_clr = '0, svc_clr = '0;
    logic [1:0] tx_ie = '0, brk_ie = '0, brk_stat = '0;
    logic [3:0] rx_mode = '0;
    logic       stat_hi = 1'b0;
    logic       irq;
    logic [7:0] pend_stat, vec;

    always #2 clk = ~clk;

    sirq_ctrl i_sirq_ctrl (
        .clk(clk), .rst(rst), .rx_req(rx_req), .tx_req(tx_req),
        .rx_clr(rx_clr), .tx_clr(tx_clr), .svc_clr(svc_clr),
        .tx_ie(tx_ie), .rx_mode(rx_mode), .brk_ie(brk_ie),
        .brk_stat(brk_stat), .stat_hi(stat_hi),
        .irq(irq), .pend_stat(pend_stat), .vec(vec)
    );

    typedef struct {
        logic [7:0] vec;
        logic [7:0] pend;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // reference state: receive/transmit pending, in service, status bit
    bit   m_rp[2], m_tp[2], m_rv[2], m_tv[2], m_rb[2], m_tb[2];
    logic [7:0] m_vec = 8'h00;

    function automatic logic [7:0] ref_code(bit hi, int ch, int kind);
        // kind: 1 none, 2 receive, 3 transmit
        if (kind == 2) return hi ? (ch == 0 ? 8'h30 : 8'h20) : (ch == 0 ? 8'h0C : 8'h04);
        if (kind == 3) return hi ? (ch == 0 ? 8'h10 : 8'h00) : (ch == 0 ? 8'h08 : 8'h00);
        return hi ? 8'h60 : 8'h06;
    endfunction

    function automatic bit ref_irq();
        bit r = 0;
        for (int c = 0; c < 2; c++) begin
            logic [1:0] md = rx_mode[2*c +: 2];
            r |= (tx_ie[c] && m_tp[c]) || ((md == 2'b01 || md == 2'b10) && m_rp[c])
                 || (brk_ie[c] && brk_stat[c]);
        end
        return r;
    endfunction

    task automatic step(input logic [1:0] rr, tr, rc, tc, ic, input string tag);
        exp_t e;
        int   ev[2];
        @(negedge clk);
        rx_req = rr; tx_req = tr; rx_clr = rc; tx_clr = tc; svc_clr = ic;
        for (int c = 0; c < 2; c++) begin
            ev[c] = 0;
            if (ic[c]) begin
                if (m_rv[c]) begin
                    m_rv[c] = 0;
                    if (m_tp[c]) begin m_tv[c] = 1; if (tx_ie[c]) m_tb[c] = 1; ev[c] = 3; end
                end else m_tv[c] = 0;
            end
            if (rc[c]) begin
                m_rp[c] = 0; m_rv[c] = 0; m_rb[c] = 0; ev[c] = 1;
                if (m_tp[c]) begin m_tv[c] = 1; if (tx_ie[c]) m_tb[c] = 1; ev[c] = 3; end
            end
            if (tc[c]) begin
                m_tp[c] = 0; m_tv[c] = 0; m_tb[c] = 0; ev[c] = 1;
                if (m_rp[c]) begin m_rv[c] = 1; m_rb[c] = 1; ev[c] = 2; end
            end
            if (rr[c]) begin m_rp[c] = 1; m_rv[c] = 1; m_rb[c] = 1; ev[c] = 2; end
            if (tr[c]) begin
                m_tp[c] = 1;
                if (!m_rv[c]) begin m_tv[c] = 1; if (tx_ie[c]) m_tb[c] = 1; ev[c] = 3; end
            end
        end
        if (ev[0] != 0)      m_vec = ref_code(stat_hi, 0, ev[0]);
        else if (ev[1] != 0) m_vec = ref_code(stat_hi, 1, ev[1]);
        e.vec  = m_vec;
        e.pend = {2'b00, m_rb[0], m_tb[0], 1'b0, m_rb[1], m_tb[1], 1'b0};
        e.irq  = ref_irq();
        e.tag  = tag;
        exp_q.push_back(e);
        @(negedge clk);
        rx_req = '0; tx_req = '0; rx_clr = '0; tx_clr = '0; svc_clr = '0;
    endtask

    task automatic idle(input string tag);
        step(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, tag);
    endtask

    // monitor: an item pushed before a rising edge is compared 1 ns after it
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                #1;
                checks++;
                if (vec !== e.vec || pend_stat !== e.pend || irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: vec=%h exp %h, pend=%h exp %h, irq=%b exp %b",
                             e.tag, vec, e.vec, pend_stat, e.pend, irq, e.irq);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not complete, exp done 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        // R11
        if (vec !== 8'h00 || pend_stat !== 8'h00 || irq !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: vec=%h pend=%h irq=%b exp 00 00 0", vec, pend_stat, irq);
        end

        tx_ie = 2'b11; rx_mode = 4'b1001; stat_hi = 1'b0;
        step(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, "R1 R3 A receive low");
        step(2'b00, 2'b01, 2'b00, 2'b00, 2'b00, "R2 A transmit held off by receive");
        step(2'b00, 2'b00, 2'b00, 2'b00, 2'b01, "R6 clear-in-service hands transmit");
        step(2'b00, 2'b00, 2'b01, 2'b00, 2'b00, "R7 A receive clear re-raises transmit");
        step(2'b00, 2'b00, 2'b00, 2'b01, 2'b00, "R8 R3 A transmit clear idle low");
        step(2'b00, 2'b10, 2'b00, 2'b00, 2'b00, "R3 R5 B transmit low");
        step(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, "R1 R3 B receive low");
        step(2'b00, 2'b00, 2'b10, 2'b00, 2'b00, "R7 B receive clear re-raises transmit");
        step(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, "R8 B transmit clear");

        stat_hi = 1'b1;
        step(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, "R4 A receive high");
        step(2'b00, 2'b10, 2'b00, 2'b00, 2'b00, "R4 B transmit high");
        step(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, "R4 B receive high");
        step(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, "R8 B transmit clear re-raises receive");
        step(2'b00, 2'b00, 2'b01, 2'b00, 2'b00, "R4 R7 A receive clear idle high");
        step(2'b00, 2'b10, 2'b00, 2'b00, 2'b01, "R2 R6 B transmit blocked then A svc clear");
        step(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, "R6 B svc clear hands transmit");
        step(2'b00, 2'b00, 2'b10, 2'b10, 2'b00, "R7 R8 B both clears");

        tx_ie = 2'b00;
        step(2'b00, 2'b01, 2'b00, 2'b00, 2'b00, "R5 R9 transmit with enable off");
        tx_ie = 2'b01;
        idle("R9 transmit enable turns irq on");
        step(2'b00, 2'b00, 2'b00, 2'b01, 2'b00, "R8 A transmit clear");

        rx_mode = 4'b0011;
        step(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, "R9 receive mode 11 gives no irq");
        rx_mode = 4'b0000;
        idle("R9 receive mode 00 gives no irq");
        rx_mode = 4'b0010;
        idle("R9 receive mode 10 gives irq");
        step(2'b00, 2'b00, 2'b01, 2'b00, 2'b00, "R7 A receive clear");

        brk_ie = 2'b01; brk_stat = 2'b01;
        idle("R9 A break enabled and set");
        brk_ie = 2'b00;
        idle("R9 A break disabled");
        brk_ie = 2'b10; brk_stat = 2'b10;
        idle("R9 B break enabled and set");
        brk_ie = 2'b00; brk_stat = 2'b00;

        step(2'b01, 2'b00, 2'b01, 2'b00, 2'b00, "R10 receive request wins over clear");
        step(2'b00, 2'b01, 2'b00, 2'b01, 2'b00, "R10 transmit request wins over clear");
        step(2'b00, 2'b00, 2'b01, 2'b01, 2'b00, "R10 A clear both");
        step(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, "R10 A vector kept over B");
        step(2'b00, 2'b00, 2'b11, 2'b00, 2'b00, "R7 both receive clear");
        stat_hi = 1'b0;
        step(2'b01, 2'b01, 2'b00, 2'b00, 2'b00, "R2 R10 same-cycle receive blocks transmit");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule